// File: doc/BRIEF.md
# Divider Setting Loader with Serial and Parallel Ports

This block holds the settings a frequency synthesizer needs from outside: a feedback divide value M, an output divide select N and a two-bit test select T. Those settings can come in two ways. One is a parallel pin bus with a latch strobe. The other is a three-wire serial port made of a serial clock, a data line and a load line. The parallel strobe acts as the mode input. While it is low, the parallel pins steer the settings. While it is high, the serial port owns them.

Every input is sampled on the system clock `clk`, and all edges on the strobe, serial clock and load line are found by comparing each sample with the previous one. A 14-bit shift register collects the serial frame. A transfer then copies its fields into the active registers. The block also drives a test pin that shows one of several internal nodes, and a flag that marks an M value outside the range in which the loop can lock.

Top module: `divcfg_loader`

## Requirements
- R1: While `par_latch` is low, `m_val` and `n_val` equal the `par_m` and `par_n` values sampled on the previous clock edge.
- R2: On the first cycle that `par_latch` is seen high after being low, the pins are captured. M, N and T then hold until `par_latch` goes low or a serial load event occurs.
- R3: With `par_latch` high and `ser_load` low, each sampled rising edge of `ser_clk` shifts `ser_data` into bit 0 of the 14-bit shift register. This leaves `m_val`, `n_val` and `t_val` unchanged.
- R4: A sampled rising edge of `ser_load` in serial mode copies the shift register into the active registers one clock later. The field layout is bits 13:12 to `t_val` (T1 in bit 13), bits 10:9 to `n_val` and bits 8:0 to `m_val`.
- R5: Frames go out first bit first in this order: T1, T0, one null slot, N1, N0, then M8 down to M0. The value sent in the null slot has no effect.
- R6: While `ser_load` stays high in serial mode, each rising edge of `ser_clk` shifts the register and updates M, N and T from the shifted contents.
- R7: After `ser_load` falls, M, N and T stay frozen while further bits are shifted in.
- R8: In serial mode `test_out` follows `t_val`. The code 00 gives a constant 0, 01 gives `ser_data`, 10 gives `fb_tap` and 11 gives `out_tap`.
- R9: `test_out` is 0 whenever `par_latch` is low.
- R10: `m_bad` is 1 exactly when `m_val` is below 8 or above 28. The value is applied unchanged either way.
- R11: During reset the shift register and `t_val` clear to 0, and `m_val` and `n_val` take the parallel pins.
- R12: While `par_latch` is low, `ser_clk` and `ser_load` edges neither shift the register nor load the settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide select |
| par_latch | input | 1 | Low: parallel pins feed through; rising: capture; high: serial mode |
| ser_clk | input | 1 | Serial shift clock, sampled |
| ser_data | input | 1 | Serial data input |
| ser_load | input | 1 | Serial transfer and pass-through control |
| fb_tap | input | 1 | Feedback divider output for the test selector |
| out_tap | input | 1 | Output clock for the test selector |
| m_val | output | 9 | Active feedback divide value |
| n_val | output | 2 | Active output divide select |
| t_val | output | 2 | Active test select, T1 in bit 1 |
| m_bad | output | 1 | Active M lies outside the lockable range |
| test_out | output | 1 | Selected test node |

## Verification
The assertions assume that `par_latch`, `ser_clk` and `ser_load` are already synchronous to `clk`. They also assume that each level of those inputs lasts at least one clock, so that every edge shows up as a single sampled change. The bench drives all inputs on the falling clock edge and holds each serial clock phase for a full cycle. A serial clock edge and a load edge never fall in the same sample. The stimulus uses random frames, divide values and tap levels, mixed with directed cases at the range limits and on the null slot.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
   typedef enum logic [1:0] {
      TSEL_LOW    = 2'b00,
      TSEL_SDI    = 2'b01,
      TSEL_FBDIV  = 2'b10,
      TSEL_OUTCLK = 2'b11
   } tsel_e;

   localparam int NULL_SLOTS = 1;
endpackage

// File: rtl/dcl_edge.sv
module dcl_edge #(
   parameter int           N    = 3,
   parameter logic [N-1:0] IDLE = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig,
   output logic [N-1:0] rise
);
   logic [N-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= IDLE;
      else        prev_q <= sig;
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      assign rise[i] = sig[i] & ~prev_q[i];
   end
endmodule

// File: rtl/dcl_shifter.sv
module dcl_shifter #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] q,
   output logic [W-1:0] q_next
);
   assign q_next = en ? {q[W-2:0], din} : q;

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_next;
   end
endmodule

// File: rtl/dcl_test_mux.sv
module dcl_test_mux #(
   parameter bit REGISTERED = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic [1:0] sel,
   input  logic       sdi,
   input  logic       fb,
   input  logic       oclk,
   output logic       test
);
   import dcl_pkg::*;

   logic pick;

   always_comb begin
      case (tsel_e'(sel))
         TSEL_SDI:    pick = sdi;
         TSEL_FBDIV:  pick = fb;
         TSEL_OUTCLK: pick = oclk;
         default:     pick = 1'b0;
      endcase
   end

   if (REGISTERED) begin : g_reg
      logic test_q;
      always_ff @(posedge clk) begin
         if (!rst_n) test_q <= 1'b0;
         else        test_q <= en & pick;
      end
      assign test = test_q;
   end else begin : g_comb
      assign test = en & pick;
   end
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader #(
   parameter int M_W      = 9,
   parameter int N_W      = 2,
   parameter int T_W      = 2,
   parameter int M_MIN    = 8,
   parameter int M_MAX    = 28,
   parameter bit TEST_REG = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] par_m,
   input  logic [N_W-1:0] par_n,
   input  logic           par_latch,
   input  logic           ser_clk,
   input  logic           ser_data,
   input  logic           ser_load,
   input  logic           fb_tap,
   input  logic           out_tap,
   output logic [M_W-1:0] m_val,
   output logic [N_W-1:0] n_val,
   output logic [T_W-1:0] t_val,
   output logic           m_bad,
   output logic           test_out
);
   import dcl_pkg::*;

   localparam int FRAME_W = T_W + NULL_SLOTS + N_W + M_W;
   localparam int M_LO    = 0;
   localparam int N_LO    = M_LO + M_W;
   localparam int T_LO    = N_LO + N_W + NULL_SLOTS;
   localparam logic [M_W-1:0] M_LO_LIM = M_W'(M_MIN);
   localparam logic [M_W-1:0] M_HI_LIM = M_W'(M_MAX);

   if (T_W != 2) begin : g_bad_tw
      $error("test select must be two bits");
   end
   if (M_MIN > M_MAX || M_MAX >= (1 << M_W)) begin : g_bad_range
      $error("lock range does not fit the M field");
   end

   function automatic logic [M_W-1:0] fld_m(input logic [FRAME_W-1:0] v);
      return v[M_LO +: M_W];
   endfunction
   function automatic logic [N_W-1:0] fld_n(input logic [FRAME_W-1:0] v);
      return v[N_LO +: N_W];
   endfunction
   function automatic logic [T_W-1:0] fld_t(input logic [FRAME_W-1:0] v);
      return v[T_LO +: T_W];
   endfunction

   logic [2:0] rise;
   logic       pl_rise, sclk_rise, sload_rise;

   dcl_edge #(.N(3), .IDLE(3'b111)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .sig   ({ser_load, ser_clk, par_latch}),
      .rise  (rise)
   );
   assign pl_rise    = rise[0];
   assign sclk_rise  = rise[1];
   assign sload_rise = rise[2];

   logic               shift_en;
   logic [FRAME_W-1:0] sr_q, sr_next;

   assign shift_en = par_latch & sclk_rise;

   dcl_shifter #(.W(FRAME_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (shift_en),
      .din    (ser_data),
      .q      (sr_q),
      .q_next (sr_next)
   );

   logic ser_take, par_take;
   assign ser_take = par_latch & ser_load & (sload_rise | sclk_rise);
   assign par_take = ~par_latch | pl_rise;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_val <= par_m;
         n_val <= par_n;
         t_val <= '0;
      end else if (ser_take) begin
         m_val <= fld_m(sr_next);
         n_val <= fld_n(sr_next);
         t_val <= fld_t(sr_next);
      end else if (par_take) begin
         m_val <= par_m;
         n_val <= par_n;
      end
   end

   assign m_bad = (m_val < M_LO_LIM) || (m_val > M_HI_LIM);

   dcl_test_mux #(.REGISTERED(TEST_REG)) u_tmux (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (par_latch),
      .sel   (t_val),
      .sdi   (ser_data),
      .fb    (fb_tap),
      .oclk  (out_tap),
      .test  (test_out)
   );
endmodule

// File: rtl/divcfg_loader_chk.sv
module divcfg_loader_chk #(
   parameter int M_W      = 9,
   parameter int N_W      = 2,
   parameter int T_W      = 2,
   parameter bit TEST_REG = 1'b0
) (
   input logic           clk,
   input logic           rst_n,
   input logic [M_W-1:0] par_m,
   input logic [N_W-1:0] par_n,
   input logic           par_latch,
   input logic           ser_clk,
   input logic           ser_data,
   input logic           ser_load,
   input logic [M_W-1:0] m_val,
   input logic [N_W-1:0] n_val,
   input logic [T_W-1:0] t_val,
   input logic           test_out
);
   logic pl_p, sc_p, sl_p;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pl_p <= 1'b1; sc_p <= 1'b1; sl_p <= 1'b1;
      end else begin
         pl_p <= par_latch; sc_p <= ser_clk; sl_p <= ser_load;
      end
   end

   logic ser_evt;
   assign ser_evt = ser_load && ((ser_clk && !sc_p) || !sl_p);

   assert_par_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !par_latch |=> (m_val == $past(par_m) && n_val == $past(par_n)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (par_latch && pl_p && !ser_evt) |=>
         ($stable(m_val) && $stable(n_val) && $stable(t_val)));

   assert_shift_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (par_latch && !ser_load && ser_clk && !sc_p) |=>
         ($stable(m_val) && $stable(t_val)));

   assert_par_ignores_serial_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !par_latch |=> $stable(t_val));

   assert_reset_clear_R11: assert property (@(posedge clk)
      !rst_n |=> (t_val == '0));

   if (!TEST_REG) begin : g_comb_chk
      assert_test_par_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !par_latch |-> !test_out);
      assert_test_sdi_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (par_latch && t_val == 2'b01) |-> (test_out == ser_data));
   end
endmodule

bind divcfg_loader divcfg_loader_chk #(
   .M_W(M_W), .N_W(N_W), .T_W(T_W), .TEST_REG(TEST_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .par_m(par_m), .par_n(par_n),
   .par_latch(par_latch), .ser_clk(ser_clk), .ser_data(ser_data),
   .ser_load(ser_load), .m_val(m_val), .n_val(n_val), .t_val(t_val),
   .test_out(test_out)
);

// File: tb/sim_divcfg_loader.sv
module sim_divcfg_loader;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [8:0] par_m = 9'd20;
   logic [1:0] par_n = 2'd2;
   logic       par_latch = 1'b1;
   logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0;
   logic       fb_tap = 1'b0, out_tap = 1'b0;
   logic [8:0] m_val;
   logic [1:0] n_val, t_val;
   logic       m_bad, test_out;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [13:0] exp_sr = '0;
   logic [8:0]  exp_m;
   logic [1:0]  exp_n, exp_t;

   always #(CLK_PERIOD/2) clk = ~clk;

   divcfg_loader u0 (
      .clk(clk), .rst_n(rst_n), .par_m(par_m), .par_n(par_n),
      .par_latch(par_latch), .ser_clk(ser_clk), .ser_data(ser_data),
      .ser_load(ser_load), .fb_tap(fb_tap), .out_tap(out_tap),
      .m_val(m_val), .n_val(n_val), .t_val(t_val), .m_bad(m_bad),
      .test_out(test_out)
   );

   function automatic logic [13:0] mk_frame(logic [1:0] t, logic nul,
                                            logic [1:0] n, logic [8:0] m);
      return {t, nul, n, m};
   endfunction

   function automatic logic bad_m(logic [8:0] m);
      return (m < 9'd8) || (m > 9'd28);
   endfunction

   function automatic logic test_ref(logic [1:0] t, logic sd, logic fb, logic oc);
      case (t)
         2'b01:   return sd;
         2'b10:   return fb;
         2'b11:   return oc;
         default: return 1'b0;
      endcase
   endfunction

   task automatic chk(input string req, input string what,
                      input int unsigned act, input int unsigned exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "m_val", m_val, exp_m);
      chk(req, "n_val", n_val, exp_n);
      chk(req, "t_val", t_val, exp_t);
      chk("R10", "m_bad", m_bad, bad_m(exp_m));
   endtask

   task automatic take_sr();
      exp_t = exp_sr[13:12];
      exp_n = exp_sr[10:9];
      exp_m = exp_sr[8:0];
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      ser_data = b;
      ser_clk  = 1'b1;
      if (par_latch) begin
         exp_sr = {exp_sr[12:0], b};
         if (ser_load) take_sr();
      end
      @(negedge clk);
      ser_clk = 1'b0;
   endtask

   task automatic send_frame(input logic [13:0] f);
      for (int i = 13; i >= 0; i--) send_bit(f[i]);
   endtask

   task automatic pulse_load();
      @(negedge clk);
      ser_load = 1'b1;
      if (par_latch) take_sr();
      @(negedge clk);
      ser_load = 1'b0;
   endtask

   task automatic check_mux(input string req);
      for (int k = 0; k < 4; k++) begin
         ser_data = 1'($urandom);
         fb_tap   = 1'($urandom);
         out_tap  = 1'($urandom);
         #1;
         chk(req, "test_out", test_out,
             par_latch ? test_ref(exp_t, ser_data, fb_tap, out_tap) : 1'b0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      exp_m = 9'd20; exp_n = 2'd2; exp_t = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all("R11");
      chk("R11", "test_out", test_out, 0);

      // R2: pins change while latched
      par_m = 9'd5; par_n = 2'd1;
      repeat (2) @(negedge clk);
      chk_all("R2");

      // R11: shift register cleared by reset
      pulse_load();
      @(negedge clk);
      chk_all("R11");

      // R5: null slot value ignored, boundaries of R10
      send_frame(mk_frame(2'b10, 1'b0, 2'b01, 9'd8));
      pulse_load();
      chk_all("R5");
      send_frame(mk_frame(2'b10, 1'b1, 2'b01, 9'd8));
      pulse_load();
      chk_all("R5");
      chk("R5", "m_val", m_val, 8);
      send_frame(mk_frame(2'b01, 1'b1, 2'b11, 9'd28));
      pulse_load();
      chk_all("R10");
      send_frame(mk_frame(2'b00, 1'b0, 2'b00, 9'd7));
      pulse_load();
      chk_all("R10");
      send_frame(mk_frame(2'b11, 1'b0, 2'b10, 9'd29));
      pulse_load();
      chk_all("R10");

      // R3: shifting without load leaves settings alone
      send_frame(mk_frame(2'b01, 1'b0, 2'b00, 9'd17));
      chk_all("R3");
      pulse_load();
      chk_all("R4");

      // R6: pass-through with load held high
      @(negedge clk);
      ser_load = 1'b1;
      take_sr();
      @(negedge clk);
      chk_all("R6");
      for (int i = 0; i < 6; i++) begin
         send_bit(1'($urandom));
         chk_all("R6");
      end
      // R7: freeze after load falls
      @(negedge clk);
      ser_load = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         send_bit(1'($urandom));
         chk_all("R7");
      end

      // random serial frames with mux checks
      for (int it = 0; it < 30; it++) begin
         send_frame(mk_frame(2'($urandom), 1'($urandom), 2'($urandom), 9'($urandom)));
         pulse_load();
         chk_all("R4");
         check_mux("R8");
      end

      // random parallel phases
      for (int it = 0; it < 20; it++) begin
         @(negedge clk);
         par_latch = 1'b0;
         par_m = 9'($urandom);
         par_n = 2'($urandom);
         exp_m = par_m; exp_n = par_n;
         @(negedge clk);
         chk_all("R1");
         check_mux("R9");
         // R12: serial activity in parallel mode
         send_bit(1'($urandom));
         pulse_load();
         chk_all("R12");
         @(negedge clk);
         par_latch = 1'b1;
         exp_m = par_m; exp_n = par_n;
         @(negedge clk);
         par_m = 9'($urandom);
         par_n = 2'($urandom);
         @(negedge clk);
         chk_all("R2");
         pulse_load();
         chk_all("R12");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule